// File: doc/BRIEF.md
# Zero-Sequence Injection Modulation Reference Generator

This block turns one three-phase set of signed fixed-point reference samples into three modulating samples for a carrier-comparison stage. It adds one shared common-mode term to every phase. The term comes from a single offset equation. A blending coefficient a0 decides where the term lands. With a0 = 1/2 the result is the centred space-vector style waveform. With a0 = 0 or a0 = 1 the phase with the lowest or the highest value is pinned to a DC rail. Pinning a phase removes its switching for that interval. Over a fundamental cycle, each phase sits on a rail for 120 electrical degrees, which cuts switching events by roughly one third.

A mode code picks the scheme. Three modes fix a0. The sign-driven modes choose a0 for each sample from the sign of (max + min). That sign is taken either from the main set or from a second, auxiliary three-phase set supplied alongside it. The rail value Vdc/2 is a parameter, `HALF_DC`. Every output is limited to the range ±`HALF_DC`. The block computes nothing on its own initiative: sinusoid generation and the carrier compare stay outside it.

Top module: `zsi_ref_gen`

## Requirements
- R1: Each sample accepted with `in_valid` high produces exactly one `out_valid` pulse 3 clock cycles later. A new sample may be presented on every cycle, and `out_valid` is low in every other cycle.
- R2: While `rst_n` is low at a clock edge, `out_valid` and all three modulating outputs are 0 after that edge.
- R3: Each output equals its own phase input plus one offset z, saturated as in R10. The same z applies to all three phases of a sample. Vmax and Vmin are the largest and smallest of the three main phase inputs.
- R4: Mode codes 0 and 7 (a0 = 1/2) give z = -((Vmax + Vmin) >>> 1), where >>> is an arithmetic shift that rounds toward minus infinity.
- R5: Mode code 1 (a0 = 0) gives z = -HALF_DC - Vmin, so the lowest output of the sample equals -HALF_DC.
- R6: Mode code 2 (a0 = 1) gives z = HALF_DC - Vmax, so the highest output of the sample equals +HALF_DC.
- R7: Mode code 3 uses the R5 offset when Vmax + Vmin < 0 and the R6 offset otherwise.
- R8: Mode code 5 reverses the R7 rule: it uses the R6 offset when Vmax + Vmin < 0 and the R5 offset otherwise.
- R9: Mode codes 4 and 6 follow the R7 rule, but the sign test uses the max plus min of the auxiliary set. Vmax and Vmin in the offset still come from the main set.
- R10: Any output whose sum falls outside the range -HALF_DC to +HALF_DC is clamped to the nearer limit.
- R11: The mode code and the auxiliary inputs are captured only together with `in_valid`. Changing them between strobes does not alter a sample already accepted. The auxiliary inputs have no effect in modes 0, 1, 2, 3, 5 and 7.
- R12: While `out_valid` is low, the three outputs keep the values of the last emitted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one sample per high cycle |
| mode_sel | input | 3 | Scheme code, captured with the strobe |
| ph_a | input | W | Main phase A reference, signed |
| ph_b | input | W | Main phase B reference, signed |
| ph_c | input | W | Main phase C reference, signed |
| aux_a | input | W | Auxiliary phase A reference, signed |
| aux_b | input | W | Auxiliary phase B reference, signed |
| aux_c | input | W | Auxiliary phase C reference, signed |
| out_valid | output | 1 | Modulating sample strobe |
| mod_a | output | W | Phase A modulating sample, signed |
| mod_b | output | W | Phase B modulating sample, signed |
| mod_c | output | W | Phase C modulating sample, signed |

## Verification
The hardest case to reach from the ports is a sample in which the sign of the auxiliary set's max plus min disagrees with the main set's sign. Only then does the choice of set in modes 4 and 6 change the output. Random stimulus draws the two sets independently, so the signs disagree in about half of the samples. A directed burst also forces opposite signs in each sign-driven mode. Another hard case is a mode change that lands while samples are still in the pipeline. The bench covers it by driving a random mode code and random data on every idle cycle between strobes, and by running back-to-back bursts with a different mode on each cycle.

// File: rtl/zsi_pkg.sv
// Shared mode codes and coefficient selector for the zero-sequence
// injection generator. Mode codes are part of the port contract.
package zsi_pkg;

    typedef enum logic [2:0] {
        MODE_CENTERED      = 3'd0,
        MODE_LOW_RAIL      = 3'd1,
        MODE_HIGH_RAIL     = 3'd2,
        MODE_SIGN_MAIN     = 3'd3,
        MODE_SIGN_AUX      = 3'd4,
        MODE_SIGN_MAIN_INV = 3'd5,
        MODE_SIGN_AUX_ALT  = 3'd6,
        MODE_SPARE         = 3'd7
    } zsi_mode_e;

    // Blending coefficient a0 restricted to the three values it can take.
    typedef enum logic [1:0] {
        A0_ZERO = 2'd0,
        A0_HALF = 2'd1,
        A0_ONE  = 2'd2
    } zsi_a0_e;

    localparam int ZSI_LATENCY = 3;

endpackage

// File: rtl/zsi_extrema.sv
// Combinational maximum and minimum of three signed samples.
// Assumes all inputs share the same signed width W.
module zsi_extrema #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x0,
    input  logic signed [W-1:0] x1,
    input  logic signed [W-1:0] x2,
    output logic signed [W-1:0] vmax,
    output logic signed [W-1:0] vmin
);

    logic signed [W-1:0] hi01;
    logic signed [W-1:0] lo01;

    // Two-level compare tree for the largest and smallest value.
    always_comb begin
        hi01 = (x0 > x1) ? x0 : x1;
        lo01 = (x0 < x1) ? x0 : x1;
        vmax = (hi01 > x2) ? hi01 : x2;
        vmin = (lo01 < x2) ? lo01 : x2;
    end

endmodule

// File: rtl/zsi_offset.sv
// Picks a0 from the mode and the sign flags, then forms the shared
// zero-sequence offset. a0 only takes 0, 1/2 or 1, so every product
// is a select or an arithmetic shift; no multiplier is built.
// Assumes vmax >= vmin and OW >= W + 2.
module zsi_offset
    import zsi_pkg::*;
#(
    parameter int W       = 16,
    parameter int OW      = W + 2,
    parameter int HALF_DC = 16384
) (
    input  logic [2:0]           mode,
    input  logic signed [W-1:0]  vmax,
    input  logic signed [W-1:0]  vmin,
    input  logic                 main_neg,
    input  logic                 aux_neg,
    output logic signed [OW-1:0] offset
);

    localparam logic signed [OW-1:0] RAIL = OW'(HALF_DC);

    zsi_a0_e             a0;
    logic signed [OW-1:0] ext_max;
    logic signed [OW-1:0] ext_min;
    logic signed [OW-1:0] ext_sum;

    // Coefficient selection; the sign modes test main or auxiliary set.
    always_comb begin
        unique case (zsi_mode_e'(mode))
            MODE_LOW_RAIL:      a0 = A0_ZERO;
            MODE_HIGH_RAIL:     a0 = A0_ONE;
            MODE_SIGN_MAIN:     a0 = main_neg ? A0_ZERO : A0_ONE;
            MODE_SIGN_MAIN_INV: a0 = main_neg ? A0_ONE  : A0_ZERO;
            MODE_SIGN_AUX,
            MODE_SIGN_AUX_ALT:  a0 = aux_neg  ? A0_ZERO : A0_ONE;
            default:            a0 = A0_HALF;
        endcase
    end

    // Offset equation evaluated for the selected coefficient.
    always_comb begin
        ext_max = OW'(vmax);
        ext_min = OW'(vmin);
        ext_sum = ext_max + ext_min;
        unique case (a0)
            A0_ZERO: offset = -RAIL - ext_min;
            A0_ONE:  offset = RAIL - ext_max;
            default: offset = -(ext_sum >>> 1);
        endcase
    end

endmodule

// File: rtl/zsi_sat_add.sv
// Adds the shared offset to one phase and clamps the result to the
// symmetric rail +/-HALF_DC. Assumes HALF_DC < 2**(W-1).
module zsi_sat_add #(
    parameter int W       = 16,
    parameter int OW      = W + 2,
    parameter int HALF_DC = 16384
) (
    input  logic signed [W-1:0]  x,
    input  logic signed [OW-1:0] offset,
    output logic signed [W-1:0]  y
);

    localparam int SW = OW + 1;
    localparam logic signed [SW-1:0] LIM_HI = SW'(HALF_DC);
    localparam logic signed [SW-1:0] LIM_LO = -SW'(HALF_DC);

    logic signed [SW-1:0] total;

    // Full-width sum followed by a two-sided clamp.
    always_comb begin
        total = SW'(x) + SW'(offset);
        if (total > LIM_HI) begin
            y = W'(LIM_HI);
        end else if (total < LIM_LO) begin
            y = W'(LIM_LO);
        end else begin
            y = W'(total);
        end
    end

endmodule

// File: rtl/zsi_ref_gen.sv
// Zero-sequence injection reference generator, top level.
// Stage 1 captures a sample with its mode and extrema, stage 2 forms the
// offset, stage 3 adds and clamps. Fixed latency of three cycles, one
// sample per cycle. Mode and auxiliary data travel with the sample.
module zsi_ref_gen
    import zsi_pkg::*;
#(
    parameter int W       = 16,
    parameter int HALF_DC = 16384
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          mode_sel,
    input  logic signed [W-1:0] ph_a,
    input  logic signed [W-1:0] ph_b,
    input  logic signed [W-1:0] ph_c,
    input  logic signed [W-1:0] aux_a,
    input  logic signed [W-1:0] aux_b,
    input  logic signed [W-1:0] aux_c,
    output logic                out_valid,
    output logic signed [W-1:0] mod_a,
    output logic signed [W-1:0] mod_b,
    output logic signed [W-1:0] mod_c
);

    localparam int OW     = W + 2;
    localparam int NPHASE = 3;

    logic signed [W-1:0]  in_ph  [NPHASE];
    logic signed [W-1:0]  in_max, in_min, ax_max, ax_min;
    logic signed [W:0]    ax_sum, mn_sum;

    logic                 s1_vld;
    logic [2:0]           s1_mode;
    logic signed [W-1:0]  s1_ph  [NPHASE];
    logic signed [W-1:0]  s1_max, s1_min;
    logic                 s1_aux_neg, s1_main_neg;

    logic signed [OW-1:0] off_c;
    logic                 s2_vld;
    logic signed [W-1:0]  s2_ph  [NPHASE];
    logic signed [OW-1:0] s2_off;

    logic signed [W-1:0]  sat_y  [NPHASE];
    logic signed [W-1:0]  s3_y   [NPHASE];
    logic                 s3_vld;

    assign in_ph[0] = ph_a;
    assign in_ph[1] = ph_b;
    assign in_ph[2] = ph_c;

    zsi_extrema #(.W(W)) u_main_ext (
        .x0(ph_a), .x1(ph_b), .x2(ph_c), .vmax(in_max), .vmin(in_min)
    );

    zsi_extrema #(.W(W)) u_aux_ext (
        .x0(aux_a), .x1(aux_b), .x2(aux_c), .vmax(ax_max), .vmin(ax_min)
    );

    // Sign sources for the sign-driven modes, widened to avoid overflow.
    always_comb begin
        mn_sum = (W+1)'(in_max) + (W+1)'(in_min);
        ax_sum = (W+1)'(ax_max) + (W+1)'(ax_min);
    end

    // Stage 1: capture sample, extrema, signs and mode on the strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld      <= 1'b0;
            s1_mode     <= 3'd0;
            s1_max      <= '0;
            s1_min      <= '0;
            s1_aux_neg  <= 1'b0;
            s1_main_neg <= 1'b0;
            for (int i = 0; i < NPHASE; i++) s1_ph[i] <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_mode     <= mode_sel;
                s1_max      <= in_max;
                s1_min      <= in_min;
                s1_main_neg <= mn_sum[W];
                s1_aux_neg  <= ax_sum[W];
                for (int i = 0; i < NPHASE; i++) s1_ph[i] <= in_ph[i];
            end
        end
    end

    zsi_offset #(.W(W), .OW(OW), .HALF_DC(HALF_DC)) u_offset (
        .mode(s1_mode), .vmax(s1_max), .vmin(s1_min),
        .main_neg(s1_main_neg), .aux_neg(s1_aux_neg), .offset(off_c)
    );

    // Stage 2: hold the offset alongside the phases it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_off <= '0;
            for (int i = 0; i < NPHASE; i++) s2_ph[i] <= '0;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_off <= off_c;
                for (int i = 0; i < NPHASE; i++) s2_ph[i] <= s1_ph[i];
            end
        end
    end

    // One saturating adder per phase.
    for (genvar g = 0; g < NPHASE; g++) begin : g_phase
        zsi_sat_add #(.W(W), .OW(OW), .HALF_DC(HALF_DC)) u_sat (
            .x(s2_ph[g]), .offset(s2_off), .y(sat_y[g])
        );
    end

    // Stage 3: output registers, updated only for a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_vld <= 1'b0;
            for (int i = 0; i < NPHASE; i++) s3_y[i] <= '0;
        end else begin
            s3_vld <= s2_vld;
            if (s2_vld) begin
                for (int i = 0; i < NPHASE; i++) s3_y[i] <= sat_y[i];
            end
        end
    end

    assign out_valid = s3_vld;
    assign mod_a     = s3_y[0];
    assign mod_b     = s3_y[1];
    assign mod_c     = s3_y[2];

endmodule

// File: rtl/zsi_ref_gen_chk.sv
// Property checker for zsi_ref_gen, attached by bind. It observes the
// ports only and waits three cycles after reset before any look-back.
module zsi_ref_gen_chk #(
    parameter int W       = 16,
    parameter int HALF_DC = 16384
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2:0]          mode_sel,
    input logic                out_valid,
    input logic signed [W-1:0] mod_a,
    input logic signed [W-1:0] mod_b,
    input logic signed [W-1:0] mod_c
);

    localparam logic signed [W-1:0] RAIL = W'(HALF_DC);

    logic [1:0] age;
    logic       warm;

    // Counts cycles since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age == 2'd3);

    // R2: reset clears the strobe.
    a_r2_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R1: strobe follows the input strobe by exactly three cycles.
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R10: every emitted sample stays inside the rails.
    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mod_a <= RAIL && mod_a >= -RAIL &&
                       mod_b <= RAIL && mod_b >= -RAIL &&
                       mod_c <= RAIL && mod_c >= -RAIL));

    // R5: low-rail mode pins one phase to the negative rail.
    a_r5_low_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(mode_sel, 3) == 3'd1) |->
        (mod_a == -RAIL || mod_b == -RAIL || mod_c == -RAIL));

    // R6: high-rail mode pins one phase to the positive rail.
    a_r6_high_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(mode_sel, 3) == 3'd2) |->
        (mod_a == RAIL || mod_b == RAIL || mod_c == RAIL));

    // R12: outputs hold while no sample is emitted.
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !out_valid) |->
        ($stable(mod_a) && $stable(mod_b) && $stable(mod_c)));

endmodule

bind zsi_ref_gen zsi_ref_gen_chk #(.W(W), .HALF_DC(HALF_DC)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
    .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c)
);

// File: tb/zsi_ref_gen_bench.sv
// Self-checking bench: directed corner bursts plus seeded random bursts,
// checked against a reference model written from the requirements.
module zsi_ref_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int H          = 16384;
    localparam int MAXB       = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [2:0]          mode_sel = 3'd0;
    logic signed [W-1:0] ph_a = '0, ph_b = '0, ph_c = '0;
    logic signed [W-1:0] aux_a = '0, aux_b = '0, aux_c = '0;
    logic                out_valid;
    logic signed [W-1:0] mod_a, mod_b, mod_c;

    int n_tests = 0;
    int n_fail  = 0;

    int    sa [MAXB], sb [MAXB], sc [MAXB];
    int    xa [MAXB], xb [MAXB], xc [MAXB];
    int    md [MAXB];
    string tg [MAXB];

    zsi_ref_gen #(.W(W), .HALF_DC(H)) u_zsi_ref_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_sel(mode_sel),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
        .aux_a(aux_a), .aux_b(aux_b), .aux_c(aux_c),
        .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic int max3(int a, int b, int c);
        int m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int min3(int a, int b, int c);
        int m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

    function automatic int clampv(int v);
        if (v > H) return H;
        if (v < -H) return -H;
        return v;
    endfunction

    // Offset per R4..R9: the choice of rail from the mode and signs.
    function automatic int model_z(int i);
        int mx   = max3(sa[i], sb[i], sc[i]);
        int mn   = min3(sa[i], sb[i], sc[i]);
        int sm   = mx + mn;
        int sx   = max3(xa[i], xb[i], xc[i]) + min3(xa[i], xb[i], xc[i]);
        int low  = -H - mn;
        int high = H - mx;
        case (md[i])
            1:       return low;
            2:       return high;
            3:       return (sm < 0) ? low : high;
            5:       return (sm < 0) ? high : low;
            4, 6:    return (sx < 0) ? low : high;
            default: return -(sm >>> 1);
        endcase
    endfunction

    task automatic check_val(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd(int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    task automatic drive_idle();
        in_valid = 1'b0;
        mode_sel = 3'($urandom_range(7));
        ph_a = W'(rnd(30000)); ph_b = W'(rnd(30000)); ph_c = W'(rnd(30000));
        aux_a = W'(rnd(30000)); aux_b = W'(rnd(30000)); aux_c = W'(rnd(30000));
    endtask

    // Drives n back-to-back samples and checks each three cycles later.
    task automatic run_burst(int n);
        int z, la, lb, lc;
        for (int cyc = 0; cyc < n + 3; cyc++) begin
            if (cyc >= 3) begin
                z = model_z(cyc - 3);
                check_val("R1", "strobe", int'(out_valid), 1);
                check_val(tg[cyc-3], "mod_a", int'(mod_a), clampv(sa[cyc-3] + z));
                check_val(tg[cyc-3], "mod_b", int'(mod_b), clampv(sb[cyc-3] + z));
                check_val(tg[cyc-3], "mod_c", int'(mod_c), clampv(sc[cyc-3] + z));
            end else begin
                check_val("R1", "idle strobe", int'(out_valid), 0);
            end
            if (cyc < n) begin
                in_valid = 1'b1;
                mode_sel = 3'(md[cyc]);
                ph_a = W'(sa[cyc]); ph_b = W'(sb[cyc]); ph_c = W'(sc[cyc]);
                aux_a = W'(xa[cyc]); aux_b = W'(xb[cyc]); aux_c = W'(xc[cyc]);
            end else begin
                drive_idle();
            end
            @(negedge clk);
        end
        la = int'(mod_a); lb = int'(mod_b); lc = int'(mod_c);
        @(negedge clk);
        check_val("R12", "strobe low", int'(out_valid), 0);
        check_val("R12", "hold a", int'(mod_a), la);
        check_val("R12", "hold b", int'(mod_b), lb);
        check_val("R12", "hold c", int'(mod_c), lc);
    endtask

    task automatic set_s(int i, int m, int a, int b, int c,
                         int x0, int x1, int x2, string t);
        md[i] = m; sa[i] = a; sb[i] = b; sc[i] = c;
        xa[i] = x0; xb[i] = x1; xc[i] = x2; tg[i] = t;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        check_val("R2", "strobe in reset", int'(out_valid), 0);
        check_val("R2", "mod_a in reset", int'(mod_a), 0);
        check_val("R2", "mod_b in reset", int'(mod_b), 0);
        check_val("R2", "mod_c in reset", int'(mod_c), 0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Fixed-coefficient modes, including the odd sum for R4 rounding.
        set_s(0, 0, 1000, -3001, 500, 0, 0, 0, "R4");
        set_s(1, 7, 9000, 2000, -1000, 0, 0, 0, "R4");
        set_s(2, 1, 3000, -2000, 100, 9, 9, 9, "R5");
        set_s(3, 2, 3000, -2000, 100, -9, -9, -9, "R6");
        run_burst(4);

        // Sign modes with main and auxiliary signs in disagreement.
        set_s(0, 3, -5000, 1000, 2000, 8000, 7000, 6000, "R7");
        set_s(1, 3, 5000, -1000, -2000, -8000, -7000, -6000, "R7");
        set_s(2, 5, -5000, 1000, 2000, 8000, 7000, 6000, "R8");
        set_s(3, 5, 5000, -1000, -2000, -8000, -7000, -6000, "R8");
        set_s(4, 4, -5000, 1000, 2000, 8000, 7000, 6000, "R9");
        set_s(5, 6, 5000, -1000, -2000, -8000, -7000, -6000, "R9");
        set_s(6, 4, 0, 0, 0, -1, 0, 0, "R9");
        set_s(7, 3, 0, 0, 0, -30000, -30000, -30000, "R11");
        run_burst(8);

        // Saturation on both rails and zero-sum boundary.
        set_s(0, 1, 20000, -20000, 0, 0, 0, 0, "R10");
        set_s(1, 0, 20000, -20000, 0, 0, 0, 0, "R10");
        set_s(2, 2, 32767, -32768, 0, 0, 0, 0, "R10");
        set_s(3, 0, -32768, -32768, -32768, 0, 0, 0, "R3");
        run_burst(4);

        // Single samples, mode changed on idle cycles between strobes.
        for (int k = 0; k < 6; k++) begin
            set_s(0, k % 3, rnd(16000), rnd(16000), rnd(16000),
                  rnd(16000), rnd(16000), rnd(16000), "R11");
            run_burst(1);
        end

        // Seeded random bursts across all modes.
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < MAXB; i++) begin
                set_s(i, int'($urandom_range(7)), rnd(18000), rnd(18000),
                      rnd(18000), rnd(18000), rnd(18000), rnd(18000), "R3");
            end
            run_burst(1 + int'($urandom_range(MAXB - 1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule